// File: doc/BRIEF.md
# Two-Stage Supply Supervisor with Power-Down Wakeup

This block watches a sampled supply-voltage code and reacts in two stages. When the code drops below the upper, warning level, it raises a raw warning status. That status reaches the interrupt line only while the interrupt-enable input is set. When the code drops below the lower level, the block holds the chip in reset until the supply has clearly recovered. Each stage has its own pair of programmable codes: one where it asserts and a higher one where it releases. Because of this hysteresis, a supply that hovers near a threshold does not make the outputs toggle.

The block also runs the exit from power-down. A power-down request is accepted only while no chip reset is active. Once the block is asleep, the supply warning or any external wake source starts a programmable wakeup delay, and a one-cycle resume pulse marks its end. External wake sources leave latched cause flags. A wake caused by the warning leaves no flag. If the supply recovers before the delay ends, the core therefore resumes with no interrupt, no flag and no brown-out reset cause. Software can read that empty state as a brown-out that has passed.

A reset-cause register records power-on, software and brown-out resets. A software reset does not disturb the brown-out cause. Both registers are read through a small read port and cleared by writing ones.

Top module: `bod_supervisor`

## Requirements
- R1: The warning stage is registered. It asserts one cycle after the voltage code is below `warn_on_i` and releases one cycle after the code is at or above `warn_off_i`. Between the two levels it holds its state.
- R2: `irq_o` equals `warn_raw_o` while `irq_en_i` is 1 and is 0 while `irq_en_i` is 0. The change follows the enable without delay.
- R3: The brown-out reset stage asserts one cycle after the code is below `rst_on_i`. It then holds `chip_rst_o` high for any code below `rst_off_i`, down to code 0. It releases one cycle after the code is at or above `rst_off_i`.
- R4: Reading address 0 returns the reset-cause register: bit 0 power-on, bit 1 software, bit 2 brown-out, all other bits 0. While `por_i` is high this register becomes 0b001.
- R5: A cycle with `sw_rst_req_i` high gives a one-cycle `chip_rst_o` pulse in the next cycle and sets cause bit 1 without altering bit 2. The start of a brown-out reset sets cause bit 2.
- R6: A write (`wr_en_i`) to address 0 or address 1 clears exactly the bits that are 1 in `wr_data_i`. The other bits keep their values.
- R7: `pd_req_i` is ignored while `chip_rst_o` is high. An active chip reset ends any power-down and drives `pd_active_o` low one cycle later.
- R8: While the block is asleep, a registered warning or any `ext_wake_i` bit starts the wakeup delay. `resume_o` pulses for one cycle exactly `wake_dly_i` cycles later, with a value of 0 treated as 1. `pd_active_o` stays high from the accepted request until that pulse.
- R9: An `ext_wake_i` bit that ends power-down sets the same bit of the wake-flag register at address 1. `ext_wake_i` while running, and a wake caused by the warning, set no flag.
- R10: If the warning clears during the wakeup delay, the core resumes with `irq_o` low, all wake flags 0 and cause bit 2 at 0.
- R11: `por_i` clears all wake flags and, after release, leaves the block running with the warning and the brown-out reset inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| vcode_i | input | 10 | Sampled supply-voltage code, unsigned |
| warn_on_i | input | 10 | Warning assert level |
| warn_off_i | input | 10 | Warning release level, higher than the assert level |
| rst_on_i | input | 10 | Brown-out reset assert level |
| rst_off_i | input | 10 | Brown-out reset release level |
| irq_en_i | input | 1 | Interrupt enable for the warning |
| sw_rst_req_i | input | 1 | Software reset request |
| pd_req_i | input | 1 | Power-down entry request |
| ext_wake_i | input | 4 | External wake sources |
| wake_dly_i | input | 16 | Wakeup delay in cycles |
| wr_en_i | input | 1 | Write-one-to-clear strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 8 | Write data, ones clear bits |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 8 | Read data, combinational |
| warn_raw_o | output | 1 | Raw warning status |
| irq_o | output | 1 | Warning interrupt |
| chip_rst_o | output | 1 | Chip reset |
| pd_active_o | output | 1 | Power-down or wakeup delay in progress |
| resume_o | output | 1 | One-cycle pulse when the core resumes |

## Verification
The warning, the brown-out reset, the cause bits and the software-reset pulse all change one clock edge after their stimulus. The bench drives each input on a falling edge and samples on the following falling edge. `irq_o` and the read port are combinational, so the bench samples them a moment after changing the enable or the address. For the wakeup the bench counts edges exactly: power-down starts one edge after the request, and the flag latches on the edge that sees a wake source. The resume pulse comes `wake_dly_i` edges later. A warning needs one extra edge to reach the wake logic, and the silent-recovery test accounts for it.

// File: rtl/bod_pkg.sv
package bod_pkg;

    localparam int unsigned VCODE_W  = 10;
    localparam int unsigned DLY_W    = 16;
    localparam int unsigned NUM_WAKE = 4;
    localparam int unsigned REG_W    = 8;
    localparam int unsigned ADDR_W   = 2;
    localparam int unsigned NUM_STG  = 2;

    // stage indices
    localparam int unsigned STG_WARN = 0;
    localparam int unsigned STG_BOD  = 1;

    localparam logic [ADDR_W-1:0] ADDR_CAUSE = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_WFLAG = ADDR_W'(1);

    typedef enum logic [1:0] {
        WS_RUN   = 2'd0,
        WS_SLEEP = 2'd1,
        WS_WAKE  = 2'd2
    } wake_state_e;

    // bit 2 brown-out, bit 1 software, bit 0 power-on
    typedef struct packed {
        logic bod;
        logic sw;
        logic por;
    } cause_t;

    localparam int unsigned CAUSE_W = $bits(cause_t);

    function automatic logic w1c_hit(input logic en, input logic [ADDR_W-1:0] addr,
                                     input logic [ADDR_W-1:0] target);
        return en && (addr == target);
    endfunction

endpackage

// File: rtl/bod_hyst_stage.sv
module bod_hyst_stage
    import bod_pkg::*;
#(
    parameter int unsigned VW = VCODE_W
) (
    input  logic          clk,
    input  logic          por_i,
    input  logic [VW-1:0] code_i,
    input  logic [VW-1:0] on_lvl_i,
    input  logic [VW-1:0] off_lvl_i,
    output logic          active_o,
    output logic          set_evt_o
);

    logic act_q;
    logic clr_evt;

    assign set_evt_o = !act_q && (code_i < on_lvl_i);
    assign clr_evt   = act_q && (code_i >= off_lvl_i);
    assign active_o  = act_q;

    always_ff @(posedge clk) begin
        if (por_i) begin
            act_q <= 1'b0;
        end else if (set_evt_o) begin
            act_q <= 1'b1;
        end else if (clr_evt) begin
            act_q <= 1'b0;
        end
    end

endmodule

// File: rtl/bod_wake_fsm.sv
module bod_wake_fsm
    import bod_pkg::*;
#(
    parameter int unsigned DW = DLY_W,
    parameter int unsigned NW = NUM_WAKE
) (
    input  logic          clk,
    input  logic          por_i,
    input  logic          chip_rst_i,
    input  logic          pd_req_i,
    input  logic          warn_i,
    input  logic [NW-1:0] ext_wake_i,
    input  logic [DW-1:0] dly_i,
    output logic          pd_active_o,
    output logic          resume_o,
    output logic [NW-1:0] latch_o
);

    wake_state_e st_q, st_d;
    logic [DW-1:0] cnt_q;
    logic          resume_q;
    logic          wake_evt;
    logic          delay_done;

    assign wake_evt   = warn_i || (|ext_wake_i);
    assign delay_done = (cnt_q <= DW'(1));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WS_RUN:   if (pd_req_i) st_d = WS_SLEEP;
            WS_SLEEP: if (wake_evt) st_d = WS_WAKE;
            WS_WAKE:  if (delay_done) st_d = WS_RUN;
            default:  st_d = WS_RUN;
        endcase
        if (chip_rst_i) begin
            st_d = WS_RUN;
        end
    end

    // only external sources leave a flag, and only when they end sleep
    assign latch_o = (st_q == WS_SLEEP && !chip_rst_i) ? ext_wake_i : '0;

    always_ff @(posedge clk) begin
        if (por_i) begin
            st_q     <= WS_RUN;
            cnt_q    <= '0;
            resume_q <= 1'b0;
        end else begin
            st_q     <= st_d;
            resume_q <= (st_q == WS_WAKE) && delay_done && !chip_rst_i;
            if (st_q == WS_SLEEP && st_d == WS_WAKE) begin
                cnt_q <= dly_i;
            end else if (st_q == WS_WAKE && !delay_done) begin
                cnt_q <= cnt_q - DW'(1);
            end
        end
    end

    assign pd_active_o = (st_q != WS_RUN);
    assign resume_o    = resume_q;

endmodule

// File: rtl/bod_cause_regs.sv
module bod_cause_regs
    import bod_pkg::*;
#(
    parameter int unsigned NW = NUM_WAKE,
    parameter int unsigned RW = REG_W,
    parameter int unsigned AW = ADDR_W
) (
    input  logic          clk,
    input  logic          por_i,
    input  logic          bod_set_i,
    input  logic          sw_set_i,
    input  logic [NW-1:0] wake_set_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [RW-1:0] wr_data_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [RW-1:0] rd_data_o
);

    cause_t        cause_q, cause_d;
    logic [NW-1:0] flag_q, flag_d;
    logic [CAUSE_W-1:0] cause_clr;
    logic [NW-1:0]      flag_clr;

    assign cause_clr = w1c_hit(wr_en_i, wr_addr_i, ADDR_CAUSE) ? wr_data_i[CAUSE_W-1:0] : '0;
    assign flag_clr  = w1c_hit(wr_en_i, wr_addr_i, ADDR_WFLAG) ? wr_data_i[NW-1:0] : '0;

    // new events win over a clear in the same cycle
    always_comb begin
        cause_d = cause_t'(cause_q & ~cause_clr);
        if (bod_set_i) cause_d.bod = 1'b1;
        if (sw_set_i)  cause_d.sw  = 1'b1;
        flag_d = (flag_q & ~flag_clr) | wake_set_i;
    end

    always_ff @(posedge clk) begin
        if (por_i) begin
            cause_q <= '{bod: 1'b0, sw: 1'b0, por: 1'b1};
            flag_q  <= '0;
        end else begin
            cause_q <= cause_d;
            flag_q  <= flag_d;
        end
    end

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == ADDR_CAUSE) begin
            rd_data_o = RW'(cause_q);
        end else if (rd_addr_i == ADDR_WFLAG) begin
            rd_data_o = RW'(flag_q);
        end
    end

endmodule

// File: rtl/bod_supervisor.sv
module bod_supervisor
    import bod_pkg::*;
#(
    parameter int unsigned VW = VCODE_W,
    parameter int unsigned DW = DLY_W,
    parameter int unsigned NW = NUM_WAKE,
    parameter int unsigned RW = REG_W,
    parameter int unsigned AW = ADDR_W
) (
    input  logic          clk,
    input  logic          por_i,
    input  logic [VW-1:0] vcode_i,
    input  logic [VW-1:0] warn_on_i,
    input  logic [VW-1:0] warn_off_i,
    input  logic [VW-1:0] rst_on_i,
    input  logic [VW-1:0] rst_off_i,
    input  logic          irq_en_i,
    input  logic          sw_rst_req_i,
    input  logic          pd_req_i,
    input  logic [NW-1:0] ext_wake_i,
    input  logic [DW-1:0] wake_dly_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [RW-1:0] wr_data_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [RW-1:0] rd_data_o,
    output logic          warn_raw_o,
    output logic          irq_o,
    output logic          chip_rst_o,
    output logic          pd_active_o,
    output logic          resume_o
);

    logic [NUM_STG-1:0][VW-1:0] on_lvl, off_lvl;
    logic [NUM_STG-1:0]         stg_act, stg_set;
    logic                       bod_rst;
    logic                       swr_q;
    logic                       core_rst;
    logic [NW-1:0]              wake_latch;

    assign on_lvl[STG_WARN]  = warn_on_i;
    assign off_lvl[STG_WARN] = warn_off_i;
    assign on_lvl[STG_BOD]   = rst_on_i;
    assign off_lvl[STG_BOD]  = rst_off_i;

    for (genvar g = 0; g < NUM_STG; g++) begin : g_stage
        bod_hyst_stage #(.VW(VW)) u_stage (
            .clk       (clk),
            .por_i     (por_i),
            .code_i    (vcode_i),
            .on_lvl_i  (on_lvl[g]),
            .off_lvl_i (off_lvl[g]),
            .active_o  (stg_act[g]),
            .set_evt_o (stg_set[g])
        );
    end

    assign bod_rst = stg_act[STG_BOD];

    always_ff @(posedge clk) begin
        if (por_i) begin
            swr_q <= 1'b0;
        end else begin
            swr_q <= sw_rst_req_i;
        end
    end

    assign core_rst   = bod_rst || swr_q;
    assign chip_rst_o = por_i || core_rst;
    assign warn_raw_o = stg_act[STG_WARN];
    assign irq_o      = irq_en_i && stg_act[STG_WARN];

    bod_wake_fsm #(.DW(DW), .NW(NW)) u_wake (
        .clk         (clk),
        .por_i       (por_i),
        .chip_rst_i  (core_rst),
        .pd_req_i    (pd_req_i),
        .warn_i      (stg_act[STG_WARN]),
        .ext_wake_i  (ext_wake_i),
        .dly_i       (wake_dly_i),
        .pd_active_o (pd_active_o),
        .resume_o    (resume_o),
        .latch_o     (wake_latch)
    );

    bod_cause_regs #(.NW(NW), .RW(RW), .AW(AW)) u_regs (
        .clk        (clk),
        .por_i      (por_i),
        .bod_set_i  (stg_set[STG_BOD]),
        .sw_set_i   (sw_rst_req_i),
        .wake_set_i (wake_latch),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .rd_addr_i  (rd_addr_i),
        .rd_data_o  (rd_data_o)
    );

endmodule

// File: rtl/bod_supervisor_chk.sv
module bod_supervisor_chk #(
    parameter int unsigned VW = 10
) (
    input logic          clk,
    input logic          por_i,
    input logic [VW-1:0] vcode_i,
    input logic [VW-1:0] warn_on_i,
    input logic [VW-1:0] warn_off_i,
    input logic [VW-1:0] rst_off_i,
    input logic          irq_en_i,
    input logic          bod_q,
    input logic          warn_raw_o,
    input logic          irq_o,
    input logic          chip_rst_o,
    input logic          pd_active_o,
    input logic          resume_o
);

    // R1
    warn_hold_chk: assert property (@(posedge clk) disable iff (por_i)
        (warn_raw_o && vcode_i < warn_off_i) |=> warn_raw_o);

    // R1
    warn_quiet_chk: assert property (@(posedge clk) disable iff (por_i)
        (!warn_raw_o && vcode_i >= warn_on_i) |=> !warn_raw_o);

    // R2
    irq_mask_chk: assert property (@(posedge clk) disable iff (por_i)
        !irq_en_i |-> !irq_o);

    // R3
    bod_hold_chk: assert property (@(posedge clk) disable iff (por_i)
        (bod_q && vcode_i < rst_off_i) |=> chip_rst_o);

    // R7
    pd_block_chk: assert property (@(posedge clk) disable iff (por_i)
        chip_rst_o |=> !pd_active_o);

    // R8
    resume_pulse_chk: assert property (@(posedge clk) disable iff (por_i)
        resume_o |=> !resume_o);

    // R8
    resume_src_chk: assert property (@(posedge clk) disable iff (por_i)
        resume_o |-> (!pd_active_o && $past(pd_active_o)));

endmodule

bind bod_supervisor bod_supervisor_chk #(.VW(VW)) u_chk (
    .clk         (clk),
    .por_i       (por_i),
    .vcode_i     (vcode_i),
    .warn_on_i   (warn_on_i),
    .warn_off_i  (warn_off_i),
    .rst_off_i   (rst_off_i),
    .irq_en_i    (irq_en_i),
    .bod_q       (bod_rst),
    .warn_raw_o  (warn_raw_o),
    .irq_o       (irq_o),
    .chip_rst_o  (chip_rst_o),
    .pd_active_o (pd_active_o),
    .resume_o    (resume_o)
);

// File: tb/bod_supervisor_tb_top.sv
`timescale 1ns/1ps
module bod_supervisor_tb_top;

    logic       clk = 1'b0;
    logic       por_i = 1'b1;
    logic [9:0] vcode_i = 10'd700;
    logic [9:0] warn_on_i = 10'd600;
    logic [9:0] warn_off_i = 10'd620;
    logic [9:0] rst_on_i = 10'd500;
    logic [9:0] rst_off_i = 10'd520;
    logic       irq_en_i = 1'b0;
    logic       sw_rst_req_i = 1'b0;
    logic       pd_req_i = 1'b0;
    logic [3:0] ext_wake_i = '0;
    logic [15:0] wake_dly_i = 16'd3;
    logic       wr_en_i = 1'b0;
    logic [1:0] wr_addr_i = '0;
    logic [7:0] wr_data_i = '0;
    logic [1:0] rd_addr_i = '0;
    logic [7:0] rd_data_o;
    logic       warn_raw_o, irq_o, chip_rst_o, pd_active_o, resume_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bod_supervisor dut_i (
        .clk(clk), .por_i(por_i), .vcode_i(vcode_i),
        .warn_on_i(warn_on_i), .warn_off_i(warn_off_i),
        .rst_on_i(rst_on_i), .rst_off_i(rst_off_i),
        .irq_en_i(irq_en_i), .sw_rst_req_i(sw_rst_req_i),
        .pd_req_i(pd_req_i), .ext_wake_i(ext_wake_i), .wake_dly_i(wake_dly_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .warn_raw_o(warn_raw_o), .irq_o(irq_o), .chip_rst_o(chip_rst_o),
        .pd_active_o(pd_active_o), .resume_o(resume_o)
    );

    typedef struct packed {
        logic [9:0] code;
        logic       warn;
        logic       bod;
    } vec_t;

    // warn levels 600/620, reset levels 500/520
    localparam vec_t VECS [12] = '{
        '{code: 10'd700, warn: 1'b0, bod: 1'b0},
        '{code: 10'd610, warn: 1'b0, bod: 1'b0},
        '{code: 10'd599, warn: 1'b1, bod: 1'b0},
        '{code: 10'd615, warn: 1'b1, bod: 1'b0},
        '{code: 10'd620, warn: 1'b0, bod: 1'b0},
        '{code: 10'd590, warn: 1'b1, bod: 1'b0},
        '{code: 10'd499, warn: 1'b1, bod: 1'b1},
        '{code: 10'd510, warn: 1'b1, bod: 1'b1},
        '{code: 10'd5,   warn: 1'b1, bod: 1'b1},
        '{code: 10'd519, warn: 1'b1, bod: 1'b1},
        '{code: 10'd520, warn: 1'b1, bod: 1'b0},
        '{code: 10'd650, warn: 1'b0, bod: 1'b0}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr_i = a;
        #0.5;
        d = rd_data_o;
    endtask

    task automatic w1c(input logic [1:0] a, input logic [7:0] d);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        tick();
        wr_en_i = 1'b0; wr_data_i = '0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        tick(); tick(); tick();
        por_i = 1'b0;
        tick();

        // reset state, R4 / R11
        rd(2'd0, d); check("R4 cause after por", d, 8'h01);
        rd(2'd1, d); check("R11 flags after por", d, 8'h00);
        check("R11 warn after por", warn_raw_o, 0);
        check("R11 chip_rst after por", chip_rst_o, 0);
        check("R7 pd_active after por", pd_active_o, 0);

        // table walk: R1 warning, R3 reset stage
        for (int i = 0; i < 12; i++) begin
            vcode_i = VECS[i].code;
            tick();
            check($sformatf("R1 warn vec %0d", i), warn_raw_o, VECS[i].warn);
            check($sformatf("R3 reset vec %0d", i), chip_rst_o, VECS[i].bod);
            check($sformatf("R2 irq masked vec %0d", i), irq_o, 0);
        end

        // R5 brown-out sets bit 2; R6 partial and full clear
        rd(2'd0, d); check("R5 cause after brown-out", d, 8'h05);
        w1c(2'd0, 8'h01);
        rd(2'd0, d); check("R6 clear por bit only", d, 8'h04);
        w1c(2'd0, 8'h04);
        rd(2'd0, d); check("R6 clear bod bit", d, 8'h00);

        // R2 enable gating
        vcode_i = 10'd590; irq_en_i = 1'b1;
        tick();
        check("R2 irq on", irq_o, 1);
        irq_en_i = 1'b0; #0.5;
        check("R2 irq masked", irq_o, 0);
        vcode_i = 10'd700;
        tick();

        // R5 software reset pulse
        sw_rst_req_i = 1'b1;
        tick();
        sw_rst_req_i = 1'b0;
        check("R5 sw pulse high", chip_rst_o, 1);
        rd(2'd0, d); check("R5 sw cause", d, 8'h02);
        tick();
        check("R5 sw pulse one cycle", chip_rst_o, 0);
        w1c(2'd0, 8'h02);
        vcode_i = 10'd499; tick();
        vcode_i = 10'd700; tick();
        rd(2'd0, d); check("R5 bod cause", d, 8'h04);
        sw_rst_req_i = 1'b1; tick(); sw_rst_req_i = 1'b0;
        rd(2'd0, d); check("R5 bod kept over sw reset", d, 8'h06);
        tick();
        w1c(2'd0, 8'h07);

        // R7 request ignored under reset
        vcode_i = 10'd499; tick();
        pd_req_i = 1'b1; tick(); pd_req_i = 1'b0;
        check("R7 pd ignored in reset", pd_active_o, 0);
        vcode_i = 10'd700; tick();
        tick();
        w1c(2'd0, 8'h07);
        rd(2'd0, d); check("R6 cause cleared", d, 8'h00);

        // R8 / R9 external wake with delay 3
        wake_dly_i = 16'd3;
        pd_req_i = 1'b1; tick(); pd_req_i = 1'b0;
        check("R8 asleep", pd_active_o, 1);
        ext_wake_i = 4'b0100; tick(); ext_wake_i = '0;
        rd(2'd1, d); check("R9 ext flag latched", d, 8'h04);
        tick(); tick();
        check("R8 still waiting", pd_active_o, 1);
        check("R8 no early resume", resume_o, 0);
        tick();
        check("R8 resume on time", resume_o, 1);
        check("R8 awake at resume", pd_active_o, 0);
        tick();
        check("R8 resume one cycle", resume_o, 0);
        ext_wake_i = 4'b0001; tick(); ext_wake_i = '0;
        rd(2'd1, d); check("R9 no flag while running", d, 8'h04);
        w1c(2'd1, 8'h04);
        rd(2'd1, d); check("R6 flag cleared", d, 8'h00);

        // R8 zero delay acts as one
        wake_dly_i = 16'd0;
        pd_req_i = 1'b1; tick(); pd_req_i = 1'b0;
        ext_wake_i = 4'b0010; tick(); ext_wake_i = '0;
        check("R8 zero delay waiting", resume_o, 0);
        tick();
        check("R8 zero delay resume", resume_o, 1);
        w1c(2'd1, 8'h0f);

        // R10 silent brown-out wake
        wake_dly_i = 16'd3; irq_en_i = 1'b1;
        pd_req_i = 1'b1; tick(); pd_req_i = 1'b0;
        vcode_i = 10'd590; tick();
        check("R8 warning seen asleep", warn_raw_o, 1);
        vcode_i = 10'd700; tick();
        check("R10 warning gone", warn_raw_o, 0);
        check("R8 delay running", pd_active_o, 1);
        tick(); tick();
        check("R10 no early resume", resume_o, 0);
        tick();
        check("R10 resume", resume_o, 1);
        check("R10 no irq", irq_o, 0);
        rd(2'd1, d); check("R10 no flags", d, 8'h00);
        rd(2'd0, d); check("R10 no bod cause", d, 8'h00);
        irq_en_i = 1'b0;

        // R11 power-on clears flags
        wake_dly_i = 16'd1;
        pd_req_i = 1'b1; tick(); pd_req_i = 1'b0;
        ext_wake_i = 4'b1000; tick(); ext_wake_i = '0;
        tick(); tick();
        rd(2'd1, d); check("R9 flag before por", d, 8'h08);
        por_i = 1'b1; tick(); tick(); por_i = 1'b0;
        tick();
        rd(2'd1, d); check("R11 flags cleared", d, 8'h00);
        rd(2'd0, d); check("R4 cause reset", d, 8'h01);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule